// File: doc/BRIEF.md
# Pipelined Instruction Fetch Master

This block is the fetch front of a processor core. It drives a read-only, pipelined memory-mapped bus and keeps several 32-bit word reads in flight at once, walking forward through memory four bytes at a time. Each returned word is paired with the address it was fetched from and placed in a small instruction queue. The queue feeds the decode stage over a ready/valid handshake.

When the core takes a branch, it pulses `redirect_i` with a new target. The queue is emptied at once, and fetching restarts at the target. Responses still due from the abandoned stream are counted and discarded as they arrive. The bus returns responses in request order, with a latency that may vary. Flow control is based on credits: the block never has more reads outstanding than the queue could still absorb, so the bus side never needs back-pressure on read data.

Top module: `fetch_master`

## Requirements
- R1: During reset and in the first cycle after it, the instruction output is not valid and the bus address equals the reset vector (default 0x0000_1000). The first words delivered come from the reset vector upward.
- R2: The block only reads: it has no write path, and every address it presents with read high has bits [1:0] equal to zero.
- R3: While read is high and waitrequest is high, read stays high and the address stays unchanged in the next cycle.
- R4: Inside one stream, each accepted request is four bytes above the previous one, and delivered words carry consecutive addresses.
- R5: No more than MAX_OUTST (default 4) accepted requests are ever waiting for data. With long latency and a ready consumer, that many reads are in flight together.
- R6: Live outstanding reads plus queued words never exceed QUEUE_DEPTH (default 8). With the consumer stalled, exactly QUEUE_DEPTH new-stream requests are issued and none of their data is lost.
- R7: Each delivered word is the data returned for the address shown beside it on `instr_addr_o`.
- R8: After a redirect that does not land on a stalled request, the next bus address is the target with bits [1:0] cleared, and the queue is emptied.
- R9: Responses to requests accepted before a redirect are dropped. The first word delivered after a redirect carries the aligned target address.
- R10: A redirect that arrives while a request is stalled by waitrequest leaves that request unchanged until it is accepted. Its response is dropped, and the next request goes to the aligned target.
- R11: While valid is high and ready is low, with no redirect, the output word and address stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| redirect_i | input | 1 | Restart fetching at `redirect_addr_i` |
| redirect_addr_i | input | 32 | Redirect target byte address |
| bus_addr_o | output | 32 | Read request address |
| bus_read_o | output | 1 | Read request |
| bus_waitreq_i | input | 1 | Slave stall; the request is accepted when low |
| bus_rdata_i | input | 32 | Returned instruction word |
| bus_rvalid_i | input | 1 | Returned word valid, in request order |
| instr_valid_o | output | 1 | Queue head valid |
| instr_ready_i | input | 1 | Consumer takes the head |
| instr_addr_o | output | 32 | Fetch address of the head word |
| instr_word_o | output | 32 | Head instruction word |

## Verification
Errors in the stale-response count show up on the first word delivered after a redirect. That word either carries an address from the abandoned stream, or the first new-stream word is lost and the sequence starts four bytes too high. Either fault is visible within one response latency of the redirect. Errors in the credit count show up at the bus port. Too many reads go out under a stalled consumer, or the in-flight count exceeds its limit, and an address-tag FIFO that falls out of step pairs every later word with the wrong address.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  localparam int unsigned FETCH_AW = 32;
  localparam int unsigned FETCH_DW = 32;

  typedef struct packed {
    logic [FETCH_AW-1:0] addr;
    logic [FETCH_DW-1:0] word;
  } fetch_entry_t;
endpackage

// File: rtl/fetch_fifo.sv
module fetch_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [W-1:0]  data_i,
  output logic [W-1:0]  data_o,
  output logic [CW-1:0] count_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= bump(wr_q);
      if (pop_i)  rd_q <= bump(rd_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  assign data_o  = mem_q[rd_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/fetch_issue.sv
module fetch_issue import fetch_pkg::*; #(
  parameter int unsigned         MAX_OUTST   = 4,
  parameter int unsigned         QUEUE_DEPTH = 8,
  parameter logic [FETCH_AW-1:0] RESET_VEC   = 32'h0000_1000,
  parameter int unsigned         OW          = $clog2(MAX_OUTST + 1),
  parameter int unsigned         QW          = $clog2(QUEUE_DEPTH + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                redirect_i,
  input  logic [FETCH_AW-1:0] redirect_addr_i,
  input  logic                waitreq_i,
  input  logic                rvalid_i,
  input  logic [OW-1:0]       outst_i,
  input  logic [QW-1:0]       qcount_i,
  output logic [FETCH_AW-1:0] addr_o,
  output logic                read_o,
  output logic                accept_o,
  output logic                keep_o
);
  localparam int unsigned SW = $clog2(MAX_OUTST + QUEUE_DEPTH + 1) + 1;

  logic [FETCH_AW-1:0] addr_q, pend_q, tgt;
  logic                stale_q, stalled;
  logic [OW-1:0]       drop_q, drop_d;
  logic [SW-1:0]       live_w, fill_w;

  assign tgt      = {redirect_addr_i[FETCH_AW-1:2], 2'b00};
  assign live_w   = SW'(outst_i) - SW'(drop_q);
  assign fill_w   = live_w + SW'(qcount_i);
  // credit: in-flight for the live stream plus queued words must fit the queue
  assign read_o   = (outst_i < OW'(MAX_OUTST)) && (fill_w < SW'(QUEUE_DEPTH));
  assign accept_o = read_o && !waitreq_i;
  assign stalled  = read_o && waitreq_i;
  assign keep_o   = rvalid_i && (drop_q == '0) && !redirect_i;
  assign addr_o   = addr_q;

  always_comb begin
    drop_d = drop_q;
    if (redirect_i) begin
      // everything still in flight after this edge belongs to the old stream
      drop_d = outst_i + OW'(accept_o) - OW'(rvalid_i);
    end else begin
      if (accept_o && stale_q)          drop_d = drop_d + OW'(1);
      if (rvalid_i && drop_q != '0)     drop_d = drop_d - OW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= {RESET_VEC[FETCH_AW-1:2], 2'b00};
      pend_q  <= '0;
      stale_q <= 1'b0;
      drop_q  <= '0;
    end else begin
      drop_q <= drop_d;
      if (redirect_i) begin
        if (stalled) begin
          stale_q <= 1'b1;
          pend_q  <= tgt;
        end else begin
          addr_q  <= tgt;
          stale_q <= 1'b0;
        end
      end else if (accept_o) begin
        if (stale_q) begin
          addr_q  <= pend_q;
          stale_q <= 1'b0;
        end else begin
          addr_q <= addr_q + FETCH_AW'(4);
        end
      end
    end
  end
endmodule

// File: rtl/fetch_master.sv
module fetch_master import fetch_pkg::*; #(
  parameter int unsigned         MAX_OUTST   = 4,
  parameter int unsigned         QUEUE_DEPTH = 8,
  parameter logic [FETCH_AW-1:0] RESET_VEC   = 32'h0000_1000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                redirect_i,
  input  logic [FETCH_AW-1:0] redirect_addr_i,
  output logic [FETCH_AW-1:0] bus_addr_o,
  output logic                bus_read_o,
  input  logic                bus_waitreq_i,
  input  logic [FETCH_DW-1:0] bus_rdata_i,
  input  logic                bus_rvalid_i,
  output logic                instr_valid_o,
  input  logic                instr_ready_i,
  output logic [FETCH_AW-1:0] instr_addr_o,
  output logic [FETCH_DW-1:0] instr_word_o
);
  localparam int unsigned OW = $clog2(MAX_OUTST + 1);
  localparam int unsigned QW = $clog2(QUEUE_DEPTH + 1);
  localparam int unsigned EW = $bits(fetch_entry_t);

  logic [OW-1:0]       outst;
  logic [QW-1:0]       qcount;
  logic                accept, keep, pop;
  logic [FETCH_AW-1:0] tag_addr;
  logic [EW-1:0]       q_in, q_out;
  fetch_entry_t        head;

  fetch_issue #(
    .MAX_OUTST(MAX_OUTST), .QUEUE_DEPTH(QUEUE_DEPTH), .RESET_VEC(RESET_VEC),
    .OW(OW), .QW(QW)
  ) u_issue (
    .clk_i, .rst_ni, .redirect_i, .redirect_addr_i,
    .waitreq_i(bus_waitreq_i), .rvalid_i(bus_rvalid_i),
    .outst_i(outst), .qcount_i(qcount),
    .addr_o(bus_addr_o), .read_o(bus_read_o),
    .accept_o(accept), .keep_o(keep)
  );

  // request-order tags: one entry per accepted read, retired by each response
  fetch_fifo #(.W(FETCH_AW), .DEPTH(MAX_OUTST), .CW(OW)) u_tags (
    .clk_i, .rst_ni, .flush_i(1'b0),
    .push_i(accept), .pop_i(bus_rvalid_i),
    .data_i(bus_addr_o), .data_o(tag_addr), .count_o(outst)
  );

  assign q_in = {tag_addr, bus_rdata_i};
  assign pop  = instr_valid_o && instr_ready_i;

  fetch_fifo #(.W(EW), .DEPTH(QUEUE_DEPTH), .CW(QW)) u_queue (
    .clk_i, .rst_ni, .flush_i(redirect_i),
    .push_i(keep), .pop_i(pop),
    .data_i(q_in), .data_o(q_out), .count_o(qcount)
  );

  assign head          = fetch_entry_t'(q_out);
  assign instr_valid_o = (qcount != '0);
  assign instr_addr_o  = head.addr;
  assign instr_word_o  = head.word;
endmodule

// File: rtl/fetch_master_chk.sv
module fetch_master_chk #(
  parameter int unsigned MAX_OUTST = 4
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        redirect_i,
  input logic [31:0] redirect_addr_i,
  input logic [31:0] bus_addr_o,
  input logic        bus_read_o,
  input logic        bus_waitreq_i,
  input logic        bus_rvalid_i,
  input logic        instr_valid_o,
  input logic        instr_ready_i,
  input logic [31:0] instr_addr_o,
  input logic [31:0] instr_word_o
);
  logic [7:0]  inflight_q;
  logic [31:0] last_q, exp_q;
  logic        have_last_q, exp_pend_q;
  logic        pop;

  assign pop = instr_valid_o && instr_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inflight_q  <= '0;
      last_q      <= '0;
      exp_q       <= '0;
      have_last_q <= 1'b0;
      exp_pend_q  <= 1'b0;
    end else begin
      inflight_q <= inflight_q + 8'(bus_read_o && !bus_waitreq_i) - 8'(bus_rvalid_i);
      if (redirect_i) begin
        have_last_q <= 1'b0;
        exp_pend_q  <= 1'b1;
        exp_q       <= redirect_addr_i & ~32'h3;
      end else if (pop) begin
        have_last_q <= 1'b1;
        last_q      <= instr_addr_o;
        exp_pend_q  <= 1'b0;
      end
    end
  end

  assert_align_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_read_o |-> bus_addr_o[1:0] == 2'b00);

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_read_o && bus_waitreq_i) |=> (bus_read_o && $stable(bus_addr_o)));

  assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inflight_q <= 8'(MAX_OUTST));

  assert_seq_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && have_last_q && !redirect_i) |-> instr_addr_o == last_q + 32'd4);

  assert_target_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_i && !(bus_read_o && bus_waitreq_i)) |=>
      bus_addr_o == ($past(redirect_addr_i) & ~32'h3));

  assert_first_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && exp_pend_q && !redirect_i) |-> instr_addr_o == exp_q);

  assert_stable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_o && !instr_ready_i && !redirect_i) |=>
      (instr_valid_o && $stable(instr_word_o) && $stable(instr_addr_o)));
endmodule

bind fetch_master fetch_master_chk #(.MAX_OUTST(MAX_OUTST)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .redirect_i(redirect_i),
  .redirect_addr_i(redirect_addr_i), .bus_addr_o(bus_addr_o),
  .bus_read_o(bus_read_o), .bus_waitreq_i(bus_waitreq_i),
  .bus_rvalid_i(bus_rvalid_i), .instr_valid_o(instr_valid_o),
  .instr_ready_i(instr_ready_i), .instr_addr_o(instr_addr_o),
  .instr_word_o(instr_word_o)
);

// File: tb/fetch_master_tb_top.sv
module fetch_master_tb_top;
  localparam int QD = 8;
  localparam int MO = 4;

  typedef struct packed {
    int          lat;
    int          wm;
    int          rm;
    logic [31:0] tgt;
    int          nw;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{1, 0, 0, 32'h0000_2000, 6},
    '{5, 1, 0, 32'h0000_3002, 8},
    '{3, 2, 1, 32'h0000_4003, 10},
    '{8, 0, 2, 32'h0000_5000, 6},
    '{2, 1, 1, 32'h0000_6ffc, 8}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        redirect = 1'b0;
  logic [31:0] redirect_addr = '0;
  logic [31:0] bus_addr, bus_rdata = '0, instr_addr, instr_word;
  logic        bus_read, bus_waitreq = 1'b1, bus_rvalid = 1'b0;
  logic        instr_valid, instr_ready = 1'b0;

  fetch_master dut_i (
    .clk_i(clk), .rst_ni(rst_n), .redirect_i(redirect), .redirect_addr_i(redirect_addr),
    .bus_addr_o(bus_addr), .bus_read_o(bus_read), .bus_waitreq_i(bus_waitreq),
    .bus_rdata_i(bus_rdata), .bus_rvalid_i(bus_rvalid),
    .instr_valid_o(instr_valid), .instr_ready_i(instr_ready),
    .instr_addr_o(instr_addr), .instr_word_o(instr_word)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int lat = 2, wmode = 0, rmode = 0;
  bit force_wait = 1'b0, done = 1'b0;
  int outst_b = 0, max_outst = 0, align_err = 0, hold_err = 0;
  bit prev_stall = 1'b0;
  logic [31:0] prev_addr = '0;
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] cap_addr[$], cap_word[$], acc_log[$], pend_addr[$];
  int pend_due[$];

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[15:0] ^ 16'hC3A5, ~a[31:16]};
  endfunction

  always @(posedge clk) begin
    cyc  <= cyc + 1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  // bus slave and consumer model, driven away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      bus_waitreq = 1'b1; bus_rvalid = 1'b0; instr_ready = 1'b0;
      pend_addr.delete(); pend_due.delete(); outst_b = 0; prev_stall = 1'b0;
    end else begin
      if (prev_stall && (!bus_read || bus_addr != prev_addr)) hold_err++;
      bus_rvalid = 1'b0;
      if (pend_addr.size() > 0 && pend_due[0] <= cyc) begin
        bus_rvalid = 1'b1;
        bus_rdata  = mem_word(pend_addr[0]);
        void'(pend_addr.pop_front()); void'(pend_due.pop_front());
        outst_b--;
      end
      case (wmode)
        1:       bus_waitreq = (cyc % 3 == 0);
        2:       bus_waitreq = lfsr[0];
        default: bus_waitreq = 1'b0;
      endcase
      if (force_wait) bus_waitreq = 1'b1;
      case (rmode)
        0:       instr_ready = 1'b1;
        1:       instr_ready = (cyc % 2 == 0);
        2:       instr_ready = (cyc % 4 == 0);
        default: instr_ready = 1'b0;
      endcase
      if (instr_valid && instr_ready) begin
        cap_addr.push_back(instr_addr); cap_word.push_back(instr_word);
      end
      if (bus_read && !bus_waitreq) begin
        pend_addr.push_back(bus_addr); pend_due.push_back(cyc + lat);
        acc_log.push_back(bus_addr);
        outst_b++;
        if (outst_b > max_outst) max_outst = outst_b;
        if (bus_addr[1:0] != 2'b00) align_err++;
      end
      prev_stall = bus_read && bus_waitreq;
      prev_addr  = bus_addr;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_redirect(input logic [31:0] t);
    @(posedge clk); #1;
    redirect = 1'b1; redirect_addr = t;
    @(posedge clk); #1;
    redirect = 1'b0;
    cap_addr.delete(); cap_word.delete(); acc_log.delete();
  endtask

  task automatic wait_caps(input int n, input string req);
    int k = 0;
    while (cap_addr.size() < n && k < 3000) begin
      @(posedge clk); k++;
    end
    #1;
    chk(cap_addr.size() >= n, req, "word count", cap_addr.size(), n);
  endtask

  task automatic check_stream(input logic [31:0] base, input int n, input string req);
    for (int k = 0; k < n && k < cap_addr.size(); k++) begin
      chk(cap_addr[k] == base + 32'(4 * k), req, "address order", cap_addr[k], base + 32'(4 * k));
      chk(cap_word[k] == mem_word(cap_addr[k]), "R7", "word/address pairing",
          cap_word[k], mem_word(cap_addr[k]));
    end
  endtask

  initial begin
    logic [31:0] held, haddr, hword;
    int cnt;
    // R1 reset state
    step(3);
    chk(instr_valid == 1'b0, "R1", "valid in reset", 32'(instr_valid), 0);
    chk(bus_addr == 32'h0000_1000, "R1", "reset vector", bus_addr, 32'h0000_1000);
    rst_n = 1'b1;
    #0;
    chk(instr_valid == 1'b0, "R1", "valid after reset", 32'(instr_valid), 0);
    wait_caps(5, "R1");
    check_stream(32'h0000_1000, 5, "R1");

    // vector table: latency, stall pattern, consumer pattern, redirect target
    for (int v = 0; v < 5; v++) begin
      lat = VECS[v].lat; wmode = VECS[v].wm; rmode = VECS[v].rm;
      do_redirect(VECS[v].tgt);
      wait_caps(VECS[v].nw, "R9");
      check_stream(VECS[v].tgt & ~32'h3, VECS[v].nw, "R8");
    end

    // R5 in-flight limit under long latency
    lat = 10; wmode = 0; rmode = 0;
    do_redirect(32'h0000_7000);
    max_outst = 0;
    step(60);
    chk(max_outst == MO, "R5", "peak reads in flight", max_outst, MO);

    // R6 credit limit with stalled consumer, then R11 output hold
    lat = 2; rmode = 3;
    do_redirect(32'h0000_9000);
    step(60);
    cnt = 0;
    foreach (acc_log[i]) if (acc_log[i] >= 32'h0000_9000 && acc_log[i] < 32'h0000_a000) cnt++;
    chk(cnt == QD, "R6", "new-stream requests while stalled", cnt, QD);
    chk(instr_valid == 1'b1, "R6", "queue holds data", 32'(instr_valid), 1);
    haddr = instr_addr; hword = instr_word;
    step(5);
    chk(instr_addr == haddr && instr_addr == 32'h0000_9000, "R11", "held address", instr_addr, haddr);
    chk(instr_word == hword, "R11", "held word", instr_word, hword);
    rmode = 0;
    wait_caps(QD, "R6");
    check_stream(32'h0000_9000, QD, "R6");

    // R10 redirect onto a stalled request
    lat = 3; wmode = 0; rmode = 0;
    step(10);
    force_wait = 1'b1;
    step(12);
    chk(bus_read == 1'b1, "R10", "request stalled", 32'(bus_read), 1);
    held = bus_addr;
    do_redirect(32'h0000_b001);
    chk(bus_addr == held, "R10", "stalled address kept", bus_addr, held);
    force_wait = 1'b0;
    step(20);
    chk(acc_log.size() >= 2, "R10", "accepts after redirect", acc_log.size(), 2);
    if (acc_log.size() >= 2) begin
      chk(acc_log[0] == held, "R10", "stalled request completes", acc_log[0], held);
      chk(acc_log[1] == 32'h0000_b000, "R10", "next request at target", acc_log[1], 32'h0000_b000);
    end
    wait_caps(3, "R10");
    check_stream(32'h0000_b000, 3, "R9");

    chk(align_err == 0, "R2", "misaligned requests", align_err, 0);
    chk(hold_err == 0, "R3", "request changed under waitrequest", hold_err, 0);
    chk(max_outst <= MO, "R5", "in-flight bound", max_outst, MO);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog run did not finish actual=%h expected=%h", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule